// File: doc/BRIEF.md
# T=0 Command Header and Procedure Byte Controller

This block sits on the card side of a character-oriented (T=0) smart card link, between a byte UART and a host that interprets commands. It captures the five header bytes of each command as they arrive from the reader, hands the complete header to the host in one pulse, and then turns the line around so the card can answer with a procedure byte. The host supplies every byte the card sends, tagged with flags. Those flags decide whether the link next carries data from the reader (receive phase) or from the card (transmit phase), and when the command is finished.

During a receive phase, the block forwards each data byte to the host and counts it against the length byte (P3). It marks the last byte as final and then switches to transmit so the status words can go out. Long receive phases are cut into fixed-size chunks, and each chunk boundary is marked for the host. During a transmit phase, it counts the data bytes the card sends against P3, where a P3 of zero stands for 256. While the card is still waiting for its first procedure byte from the host, a half-expired waiting-time pulse makes the block send the NULL byte 0x60 so the reader keeps waiting.

Top module: `t0_tpdu_ctrl`

## Requirements
- R1: After reset the block waits for the first header byte: rx_en=1, tx_en=0, and hdr_valid, rxd_valid and tx_valid are 0.
- R2: Header bytes are stored in arrival order: class, instruction, P1, P2, P3. In the cycle after P3 is accepted, hdr_valid is high for one cycle, and hdr_data holds class in bits [39:32], instruction in [31:24], P1 in [23:16], P2 in [15:8] and P3 in [7:0].
- R3: After P3 the block waits for the procedure byte with tx_en=1 and rx_en=0. The receiver (rx_en=1) is on only while collecting the header and in the receive phase.
- R4: When a host byte is accepted while waiting for the procedure byte, it is passed unchanged to tx_byte. If htx_pb_tx is set, the block enters the transmit phase (tx_en stays 1). If htx_pb_rx is set, it enters the receive phase (rx_en=1, tx_en=0).
- R5: In the receive phase, each received byte appears on rxd_byte with rxd_valid one cycle later. Byte number P3 carries rxd_final, and the block then enters the transmit phase. A P3 of 0 with htx_pb_rx goes straight to the transmit phase.
- R6: In the receive phase, every 2**CHUNK_LOG2-th byte that is not final carries rxd_flush, and reception continues.
- R7: An accepted host byte that has htx_last and htx_final set, and htx_pb_rx clear, returns the block to waiting for a new header (rx_en=1, tx_en=0).
- R8: In the transmit phase, an accepted host byte that has htx_last and htx_pb_rx set starts a new receive phase, with its byte count restarted.
- R9: In the transmit phase, tx_data_done is 1 once the number of host bytes accepted in that phase reaches P3 (256 when P3 is 0), and 0 before that.
- R10: A wt_half pulse while waiting for the procedure byte makes the block offer 0x60 on tx_byte with tx_valid=1, holding htx_ready at 0, until tx_ready accepts it. The state does not change.
- R11: A wt_half pulse in any other state has no effect: tx_valid stays 0 while no host byte is offered.
- R12: A byte received while the transmitter is enabled is ignored: no rxd_valid, and the state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte arrived from the reader |
| rx_byte | input | 8 | Received byte |
| rx_en | output | 1 | Receiver enable for the UART |
| tx_en | output | 1 | Transmitter enable for the UART |
| tx_valid | output | 1 | Byte offered to the UART transmitter |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | UART accepts tx_byte this cycle |
| hdr_valid | output | 1 | One-cycle pulse: command header complete |
| hdr_data | output | 40 | Header, class byte in the top bits |
| rxd_valid | output | 1 | Received data byte for the host |
| rxd_byte | output | 8 | Data byte for the host |
| rxd_final | output | 1 | Last data byte of the receive phase |
| rxd_flush | output | 1 | Chunk boundary, not final |
| htx_valid | input | 1 | Host offers a byte to send |
| htx_byte | input | 8 | Host byte |
| htx_pb_tx | input | 1 | After this procedure byte, card transmits |
| htx_pb_rx | input | 1 | After this byte, card receives |
| htx_last | input | 1 | Last byte of the host buffer |
| htx_final | input | 1 | Buffer ends the command |
| htx_ready | output | 1 | Host byte accepted this cycle |
| tx_data_done | output | 1 | Transmit phase has sent P3 data bytes |
| wt_half | input | 1 | Half of the waiting time has elapsed |

## Verification
The bench sets CHUNK_LOG2 to 2, so chunks are four bytes long. Receive phases of six and eight bytes therefore reach both a mid-phase flush and the case where a chunk boundary coincides with the final byte, which must then not be flagged. P3 values of 0, 2, 5, 6 and 8 cover the 256-byte transmit count at P3=0, the direct jump to transmit for an empty receive phase, and the switch from transmit back to receive.

// File: rtl/t0_tpdu_pkg.sv
package t0_tpdu_pkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 5;
  localparam int LEN_W     = 9;
  localparam logic [BYTE_W-1:0] NULL_PB = 8'h60;

  // header collection states first: their encoding is the header byte index
  typedef enum logic [2:0] {
    ST_CLA, ST_INS, ST_P1, ST_P2, ST_P3, ST_PB, ST_RX, ST_TX
  } t0_state_e;

  // byte count of a card-to-reader data phase
  function automatic logic [LEN_W-1:0] out_len(input logic [BYTE_W-1:0] p3);
    return (p3 == '0) ? LEN_W'(256) : LEN_W'(p3);
  endfunction
endpackage

// File: rtl/t0_hdr_store.sv
module t0_hdr_store
  import t0_tpdu_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [2:0]                    wr_idx,
  input  logic [BYTE_W-1:0]             wr_byte,
  input  logic                          publish,
  output logic [HDR_BYTES*BYTE_W-1:0]   hdr_flat,
  output logic                          hdr_valid
);
  for (genvar i = 0; i < HDR_BYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    logic              byte_en;
    assign byte_en = wr_en && (wr_idx == 3'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_en) byte_q <= wr_byte;
    end
    assign hdr_flat[(HDR_BYTES-1-i)*BYTE_W +: BYTE_W] = byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hdr_valid <= 1'b0;
    else        hdr_valid <= publish;
  end
endmodule

// File: rtl/t0_data_cnt.sv
module t0_data_cnt
  import t0_tpdu_pkg::*;
#(
  parameter int CHUNK_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  input  logic [BYTE_W-1:0] p3,
  input  logic              in_rx,
  input  logic              in_tx,
  output logic              rx_last,
  output logic              chunk_end,
  output logic              tx_done
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || inc) cnt_q <= cnt_d;
  end

  assign rx_last   = (cnt_inc == CNT_W'(p3));
  assign chunk_end = (cnt_inc[CHUNK_LOG2-1:0] == '0);
  assign tx_done   = in_tx && (cnt_q >= CNT_W'(out_len(p3)));

  // R5
  rx_count_below_p3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rx |-> (cnt_q < CNT_W'(p3)));
endmodule

// File: rtl/t0_null_arb.sv
module t0_null_arb
  import t0_tpdu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_pb,
  input  logic              tx_en,
  input  logic              wt_half,
  input  logic              tx_ready,
  input  logic              host_valid,
  input  logic [BYTE_W-1:0] host_byte,
  output logic              host_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte
);
  logic null_pend_q, null_pend_d, null_pend_en;

  always_comb begin
    null_pend_d = null_pend_q;
    if (null_pend_q && tx_ready) null_pend_d = 1'b0;
    else if (wt_half && in_pb)   null_pend_d = 1'b1;
  end
  assign null_pend_en = (null_pend_d != null_pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            null_pend_q <= 1'b0;
    else if (null_pend_en) null_pend_q <= null_pend_d;
  end

  assign tx_valid   = null_pend_q || (tx_en && host_valid);
  assign tx_byte    = null_pend_q ? NULL_PB : host_byte;
  assign host_ready = tx_en && !null_pend_q && tx_ready;

  // R10
  null_from_wt_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(null_pend_q) |-> $past(wt_half));
  // R11
  null_only_in_pb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    null_pend_q |-> in_pb);
endmodule

// File: rtl/t0_tpdu_ctrl.sv
module t0_tpdu_ctrl
  import t0_tpdu_pkg::*;
#(
  parameter int CHUNK_LOG2 = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  output logic        rx_en,
  output logic        tx_en,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_ready,
  output logic        hdr_valid,
  output logic [39:0] hdr_data,
  output logic        rxd_valid,
  output logic [7:0]  rxd_byte,
  output logic        rxd_final,
  output logic        rxd_flush,
  input  logic        htx_valid,
  input  logic [7:0]  htx_byte,
  input  logic        htx_pb_tx,
  input  logic        htx_pb_rx,
  input  logic        htx_last,
  input  logic        htx_final,
  output logic        htx_ready,
  output logic        tx_data_done,
  input  logic        wt_half
);
  t0_state_e st_q, st_d;
  logic hdr_wr, publish, cnt_clr, cnt_inc, host_acc;
  logic rx_last, chunk_end;
  logic rxd_valid_d, rxd_final_d, rxd_flush_d;
  logic [BYTE_W-1:0] p3;

  assign p3       = hdr_data[BYTE_W-1:0];
  assign host_acc = htx_valid && htx_ready;
  assign rx_en    = (st_q != ST_PB) && (st_q != ST_TX);
  assign tx_en    = !rx_en;

  always_comb begin
    st_d        = st_q;
    hdr_wr      = 1'b0;
    publish     = 1'b0;
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    rxd_valid_d = 1'b0;
    rxd_final_d = 1'b0;
    rxd_flush_d = 1'b0;
    case (st_q)
      ST_CLA, ST_INS, ST_P1, ST_P2, ST_P3: begin
        if (rx_valid) begin
          hdr_wr = 1'b1;
          if (st_q == ST_P3) begin
            st_d    = ST_PB;
            publish = 1'b1;
          end else begin
            st_d = t0_state_e'(st_q + 3'd1);
          end
        end
      end
      ST_RX: begin
        if (rx_valid) begin
          rxd_valid_d = 1'b1;
          if (rx_last) begin
            rxd_final_d = 1'b1;
            cnt_clr     = 1'b1;
            st_d        = ST_TX;
          end else begin
            cnt_inc     = 1'b1;
            rxd_flush_d = chunk_end;
          end
        end
      end
      default: begin
        if (host_acc) begin
          if (htx_pb_rx && (st_q == ST_PB || htx_last)) begin
            cnt_clr = 1'b1;
            st_d    = (p3 == '0) ? ST_TX : ST_RX;
          end else if (htx_last && htx_final) begin
            st_d = ST_CLA;
          end else if (st_q == ST_PB && htx_pb_tx) begin
            cnt_clr = 1'b1;
            st_d    = ST_TX;
          end else if (st_q == ST_TX) begin
            cnt_inc = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_CLA;
      rxd_valid <= 1'b0;
      rxd_final <= 1'b0;
      rxd_flush <= 1'b0;
      rxd_byte  <= '0;
    end else begin
      st_q      <= st_d;
      rxd_valid <= rxd_valid_d;
      rxd_final <= rxd_final_d;
      rxd_flush <= rxd_flush_d;
      if (rxd_valid_d) rxd_byte <= rx_byte;
    end
  end

  t0_hdr_store u_hdr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (hdr_wr),
    .wr_idx   (st_q),
    .wr_byte  (rx_byte),
    .publish  (publish),
    .hdr_flat (hdr_data),
    .hdr_valid(hdr_valid)
  );

  t0_data_cnt #(.CHUNK_LOG2(CHUNK_LOG2)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .p3       (p3),
    .in_rx    (st_q == ST_RX),
    .in_tx    (st_q == ST_TX),
    .rx_last  (rx_last),
    .chunk_end(chunk_end),
    .tx_done  (tx_data_done)
  );

  t0_null_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_pb     (st_q == ST_PB),
    .tx_en     (tx_en),
    .wt_half   (wt_half),
    .tx_ready  (tx_ready),
    .host_valid(htx_valid),
    .host_byte (htx_byte),
    .host_ready(htx_ready),
    .tx_valid  (tx_valid),
    .tx_byte   (tx_byte)
  );

  // R3
  hdr_then_pb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> (st_q == ST_PB));
  // R5
  final_enters_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_valid && rxd_final) |-> (st_q == ST_TX));
  // R6
  flush_not_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_flush |-> (rxd_valid && !rxd_final));
  // R12
  idle_state_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !host_acc) |=> $stable(st_q));
endmodule

// File: tb/test_t0_tpdu_ctrl.sv
module test_t0_tpdu_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, tx_ready = 1, htx_valid = 0, htx_pb_tx = 0, htx_pb_rx = 0;
  logic htx_last = 0, htx_final = 0, wt_half = 0;
  logic [7:0] rx_byte = 0, htx_byte = 0;
  logic rx_en, tx_en, tx_valid, hdr_valid, rxd_valid, rxd_final, rxd_flush;
  logic htx_ready, tx_data_done;
  logic [7:0] tx_byte, rxd_byte;
  logic [39:0] hdr_data;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  t0_tpdu_ctrl #(.CHUNK_LOG2(2)) i_t0_tpdu_ctrl (.*);

  // {header, 1 = card sends data}
  localparam logic [40:0] VEC [4] = '{
    {40'hA0_D6_00_00_06, 1'b0},
    {40'h00_B0_00_00_05, 1'b1},
    {40'h80_10_00_00_08, 1'b0},
    {40'hA0_C0_00_00_02, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic host_send(input logic [7:0] b, input logic pt, input logic pr,
                           input logic last, input logic fin, input bit look);
    @(negedge clk);
    htx_valid = 1; htx_byte = b; htx_pb_tx = pt; htx_pb_rx = pr;
    htx_last = last; htx_final = fin;
    #1;
    while (!htx_ready) begin @(negedge clk); #1; end
    if (look) chk("R4 byte passed", {tx_valid, tx_byte}, {1'b1, b});
    @(negedge clk);
    htx_valid = 0; htx_pb_tx = 0; htx_pb_rx = 0; htx_last = 0; htx_final = 0;
  endtask

  task automatic send_hdr(input logic [39:0] h);
    for (int i = 0; i < 5; i++) send_rx(h[39-8*i -: 8]);
    chk("R2 hdr", {hdr_valid, hdr_data}, {1'b1, h});
    chk("R3 wait pb", {rx_en, tx_en}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset", {rx_en, tx_en, hdr_valid, rxd_valid, tx_valid}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    // R11 wt_half ignored while collecting the header
    wt_half = 1; @(negedge clk); wt_half = 0;
    chk("R11 no null", tx_valid, 1'b0);
    @(negedge clk);
    chk("R11 still idle", tx_valid, 1'b0);

    foreach (VEC[v]) begin
      logic [39:0] h = VEC[v][40:1];
      int n = int'(h[7:0]);
      send_hdr(h);
      @(negedge clk);
      chk("R2 hdr pulse", hdr_valid, 1'b0);
      if (VEC[v][0]) begin
        host_send(h[31:24], 1, 0, 0, 0, 1);
        chk("R4 to tx", {rx_en, tx_en}, 2'b01);
        for (int k = 0; k < n; k++) begin
          if (k == n - 1) chk("R9 not done", tx_data_done, 1'b0);
          host_send(8'h50 + 8'(k), 0, 0, 0, 0, 0);
        end
        chk("R9 done", tx_data_done, 1'b1);
      end else begin
        host_send(h[31:24], 0, 1, 1, 0, 1);
        chk("R4 to rx", {rx_en, tx_en}, 2'b10);
        for (int k = 0; k < n; k++) begin
          send_rx(8'h30 + 8'(k));
          chk("R5 rx data", {rxd_valid, rxd_byte, rxd_final}, {1'b1, 8'h30 + 8'(k), k == n - 1});
          chk("R6 flush", rxd_flush, ((k + 1) % 4 == 0) && (k != n - 1));
        end
        chk("R5 tx after final", {rx_en, tx_en}, 2'b01);
      end
      host_send(8'h90, 0, 0, 0, 0, 0);
      chk("R7 not yet", tx_en, 1'b1);
      host_send(8'h00, 0, 0, 1, 1, 0);
      chk("R7 back to header", {rx_en, tx_en}, 2'b10);
    end

    // R10 NULL byte, R12 rx ignored in pb
    send_hdr(40'h00_A4_00_00_02);
    send_rx(8'h11);
    chk("R12 ignored", {rxd_valid, tx_en}, 2'b01);
    tx_ready = 0;
    @(negedge clk); wt_half = 1; htx_valid = 1; htx_byte = 8'hA4;
    @(negedge clk); wt_half = 0; #1;
    chk("R10 null offered", {tx_valid, tx_byte, htx_ready}, {1'b1, 8'h60, 1'b0});
    htx_valid = 0;
    @(negedge clk); tx_ready = 1;
    @(negedge clk);
    chk("R10 null gone", {tx_valid, tx_en}, 2'b01);
    host_send(8'hA4, 0, 1, 1, 0, 1);
    send_rx(8'h3F); send_rx(8'h00);
    chk("R5 short rx final", {rxd_valid, rxd_final, tx_en}, 3'b111);
    host_send(8'h90, 0, 0, 1, 1, 0);

    // R5 empty receive phase
    send_hdr(40'h80_E2_00_00_00);
    host_send(8'hE2, 0, 1, 1, 0, 1);
    chk("R5 p3 zero to tx", {rx_en, tx_en}, 2'b01);
    host_send(8'h90, 0, 0, 1, 1, 0);
    chk("R7 back", rx_en, 1'b1);

    // R9 P3 zero means 256
    send_hdr(40'h00_B0_00_00_00);
    host_send(8'hB0, 1, 0, 0, 0, 1);
    for (int k = 0; k < 255; k++) host_send(8'(k), 0, 0, 0, 0, 0);
    chk("R9 255 not done", tx_data_done, 1'b0);
    host_send(8'hFF, 0, 0, 0, 0, 0);
    chk("R9 256 done", tx_data_done, 1'b1);
    host_send(8'h90, 0, 0, 1, 1, 0);

    // R8 transmit then receive again
    send_hdr(40'h00_C2_00_00_02);
    host_send(8'hC2, 1, 0, 0, 0, 1);
    host_send(8'h01, 0, 0, 0, 0, 0);
    host_send(8'h02, 0, 0, 0, 0, 0);
    chk("R9 two done", tx_data_done, 1'b1);
    host_send(8'h61, 0, 1, 1, 0, 0);
    chk("R8 to rx", {rx_en, tx_en}, 2'b10);
    send_rx(8'h77);
    chk("R8 count restarted", {rxd_valid, rxd_final}, 2'b10);
    send_rx(8'h78);
    chk("R8 final", {rxd_valid, rxd_final, tx_en}, 3'b111);
    host_send(8'h90, 0, 0, 1, 1, 0);
    chk("R7 end", {rx_en, tx_en}, 2'b10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule